// File: doc/BRIEF.md
# Cartridge Tape Controller Register Bank

This block is the set of host-visible registers of a quarter-inch cartridge tape controller. It sits inside an 8-bit I/O window of 256 ports and decodes a handful of fixed offsets. A read/write control register drives the drive's control lines. A line-status register shows the drive handshake inputs and two sticky interrupt flags. A write-only command port sends a byte to the drive. Three write-only byte registers hold the DMA start address. The block also produces an interrupt request that is gated by a select bit.

The timer and the DMA engine sit outside this block. Each one reports to it through a single one-cycle event input: terminal count and end of command. A write of any value to a dedicated port clears both flags.

The drive's reset line must see an active pulse of a guaranteed minimum length, even when software clears the reset bit early. A small state machine stretches the pulse. Its states are RS_IDLE (reset released), RS_PULSE (minimum window counting) and RS_HELD (window done, bit still set). Its transitions are:
- IDLE→PULSE when the reset bit is seen set.
- PULSE→HELD when the count ends with the bit still set.
- PULSE→IDLE when the count ends with the bit clear.
- HELD→IDLE when the bit clears.

Top module: `tape_regfile`

## Requirements
- R1: The control register at offset 82h keeps written bits 1, 2, 5, 6 and 7 and reads them back. Bits 0, 3 and 4 always read as zero.
- R2: The drive outputs follow the control register as follows: `drv_online_n` is the inverse of bit 2, `drv_wr_en` equals bit 5, `drv_rd_en` equals bit 6 and `led_sel` equals bit 7. `drv_reset_n` is low in every cycle in which bit 1 is set.
- R3: Once bit 1 has been seen set, `drv_reset_n` stays low for at least RST_HOLD clock cycles, even if bit 1 is cleared on the very next cycle. It goes high again no more than two cycles after both the window has ended and bit 1 is clear.
- R4: The status register at offset 84h reads as follows: bit 0 = not `drv_ack_n`, bit 1 = not `drv_ready_n`, bit 2 = not `drv_exc_n`, bit 3 = `drv_dir` uninverted, bit 4 = terminal-count flag, bit 5 = end-of-command flag. Bits 6 and 7 read as zero.
- R5: A one-cycle high on `tc_pulse` sets flag bit 4, and a one-cycle high on `eoc_pulse` sets flag bit 5. Each flag stays set until it is cleared.
- R6: A write of any value to offset 88h clears both flags. An event pulse in the same cycle as that write wins for its own flag.
- R7: `irq` is high exactly when control bit 7 is set and at least one flag is set.
- R8: A write to offset 80h places the byte on `cmd_data` and raises `cmd_stb` for exactly one cycle. Examples are 40h (write data) and 80h (read data).
- R9: Writes to offsets 8Ah, 8Ch and 8Eh load bits 7:0, 15:8 and 23:16 of `dma_addr`. These offsets read as zero.
- R10: Every access gets `bus_ack` one cycle after `bus_sel`, with `bus_rdata` valid in that cycle. Unmapped offsets, and the write-only offsets 80h and 88h, read as zero. Writes to unmapped offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Port offset within the window |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid with bus_ack |
| bus_ack | output | 1 | Access acknowledge |
| drv_reset_n | output | 1 | Drive reset, active low, stretched |
| drv_online_n | output | 1 | Drive on-line, active low |
| drv_wr_en | output | 1 | Write transfer enable |
| drv_rd_en | output | 1 | Read transfer enable |
| led_sel | output | 1 | Select indicator / interrupt enable |
| drv_ack_n | input | 1 | Drive acknowledge, active low |
| drv_ready_n | input | 1 | Drive ready, active low |
| drv_exc_n | input | 1 | Drive exception, active low |
| drv_dir | input | 1 | Drive direction line, uninverted |
| cmd_data | output | 8 | Last command byte written |
| cmd_stb | output | 1 | One-cycle command strobe |
| dma_addr | output | 24 | DMA start address |
| tc_pulse | input | 1 | Terminal-count event |
| eoc_pulse | input | 1 | End-of-command event |
| irq | output | 1 | Gated interrupt request |

## Verification
The hardest case to reach from the ports is a clear write landing in exactly the same cycle as an event pulse. The bench first sets the end-of-command flag. It then drives the write to 88h and `tc_pulse` on one falling edge. A read then shows that only the terminal-count flag survives.

The second hard case is the reset bit being cleared on the cycle straight after it was set. Back-to-back writes produce this case, and the bench then counts how long `drv_reset_n` stays low against a small RST_HOLD override.

// File: rtl/tape_regs_pkg.sv
package tape_regs_pkg;
    localparam logic [7:0] OFS_CMD   = 8'h80;
    localparam logic [7:0] OFS_CTRL  = 8'h82;
    localparam logic [7:0] OFS_LSTAT = 8'h84;
    localparam logic [7:0] OFS_ICLR  = 8'h88;
    localparam logic [7:0] OFS_DMA0  = 8'h8A;
    localparam int DMA_BYTES = 3;
    localparam int NUM_FLAGS = 2;
    localparam int CB_RESET  = 1;
    localparam int CB_ONLINE = 2;
    localparam int CB_WREN   = 5;
    localparam int CB_RDEN   = 6;
    localparam int CB_SEL    = 7;
    localparam logic [7:0] CTRL_MASK = 8'hE6;

    typedef enum logic [1:0] {
        RS_IDLE,
        RS_PULSE,
        RS_HELD
    } rst_state_t;
endpackage

// File: rtl/tape_rst_stretch.sv
module tape_rst_stretch
    import tape_regs_pkg::*;
#(
    parameter int RST_HOLD = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic drv_reset_n
);
    localparam int CNT_W = $clog2(RST_HOLD + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(RST_HOLD - 1);

    rst_state_t state, nxt;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= RS_IDLE;
            cnt   <= '0;
        end else begin
            state <= nxt;
            if (state == RS_PULSE) cnt <= cnt + 1'b1;
            else                   cnt <= '0;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            RS_IDLE:  if (req) nxt = RS_PULSE;
            RS_PULSE: if (cnt == LAST) nxt = req ? RS_HELD : RS_IDLE;
            RS_HELD:  if (!req) nxt = RS_IDLE;
            default:  nxt = RS_IDLE;
        endcase
    end

    always_comb begin
        drv_reset_n = !(req || (state != RS_IDLE));
    end
endmodule

// File: rtl/tape_irq_flags.sv
module tape_irq_flags #(
    parameter int NUM = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NUM-1:0] set,
    input  logic           clr,
    output logic [NUM-1:0] flags
);
    for (genvar i = 0; i < NUM; i++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      flags[i] <= 1'b0;
            else if (set[i]) flags[i] <= 1'b1;
            else if (clr)    flags[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/tape_bus_decode.sv
module tape_bus_decode
    import tape_regs_pkg::*;
(
    input  logic                 bus_sel,
    input  logic                 bus_wr,
    input  logic [7:0]           bus_addr,
    output logic                 wr_cmd,
    output logic                 wr_ctrl,
    output logic                 wr_clr,
    output logic [DMA_BYTES-1:0] wr_dma,
    output logic                 rd_ctrl,
    output logic                 rd_stat
);
    logic wr_any, rd_any;
    assign wr_any  = bus_sel && bus_wr;
    assign rd_any  = bus_sel && !bus_wr;
    assign wr_cmd  = wr_any && (bus_addr == OFS_CMD);
    assign wr_ctrl = wr_any && (bus_addr == OFS_CTRL);
    assign wr_clr  = wr_any && (bus_addr == OFS_ICLR);
    assign rd_ctrl = rd_any && (bus_addr == OFS_CTRL);
    assign rd_stat = rd_any && (bus_addr == OFS_LSTAT);

    for (genvar i = 0; i < DMA_BYTES; i++) begin : g_dma
        assign wr_dma[i] = wr_any && (bus_addr == OFS_DMA0 + 8'(2 * i));
    end
endmodule

// File: rtl/tape_regfile.sv
module tape_regfile
    import tape_regs_pkg::*;
#(
    parameter int RST_HOLD = 5000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [7:0]  bus_addr,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata,
    output logic        bus_ack,
    output logic        drv_reset_n,
    output logic        drv_online_n,
    output logic        drv_wr_en,
    output logic        drv_rd_en,
    output logic        led_sel,
    input  logic        drv_ack_n,
    input  logic        drv_ready_n,
    input  logic        drv_exc_n,
    input  logic        drv_dir,
    output logic [7:0]  cmd_data,
    output logic        cmd_stb,
    output logic [23:0] dma_addr,
    input  logic        tc_pulse,
    input  logic        eoc_pulse,
    output logic        irq
);
    logic                 wr_cmd, wr_ctrl, wr_clr, rd_ctrl, rd_stat;
    logic [DMA_BYTES-1:0] wr_dma;
    logic [7:0]           ctrl_q;
    logic [7:0]           dma_b [DMA_BYTES];
    logic [NUM_FLAGS-1:0] flag_q;
    logic [7:0]           stat_v, rd_v;

    tape_bus_decode u_dec (
        .bus_sel (bus_sel),
        .bus_wr  (bus_wr),
        .bus_addr(bus_addr),
        .wr_cmd  (wr_cmd),
        .wr_ctrl (wr_ctrl),
        .wr_clr  (wr_clr),
        .wr_dma  (wr_dma),
        .rd_ctrl (rd_ctrl),
        .rd_stat (rd_stat)
    );

    tape_irq_flags #(.NUM(NUM_FLAGS)) u_flags (
        .clk  (clk),
        .rst_n(rst_n),
        .set  ({eoc_pulse, tc_pulse}),
        .clr  (wr_clr),
        .flags(flag_q)
    );

    tape_rst_stretch #(.RST_HOLD(RST_HOLD)) u_rst (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (ctrl_q[CB_RESET]),
        .drv_reset_n(drv_reset_n)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q    <= '0;
            cmd_data  <= '0;
            cmd_stb   <= 1'b0;
            bus_ack   <= 1'b0;
            bus_rdata <= '0;
        end else begin
            if (wr_ctrl) ctrl_q <= bus_wdata & CTRL_MASK;
            if (wr_cmd)  cmd_data <= bus_wdata;
            cmd_stb   <= wr_cmd;
            bus_ack   <= bus_sel;
            bus_rdata <= bus_sel ? rd_v : 8'h00;
        end
    end

    for (genvar i = 0; i < DMA_BYTES; i++) begin : g_dma
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         dma_b[i] <= '0;
            else if (wr_dma[i]) dma_b[i] <= bus_wdata;
        end
        assign dma_addr[8*i +: 8] = dma_b[i];
    end

    always_comb begin
        stat_v = {2'b00, flag_q[1], flag_q[0], drv_dir, !drv_exc_n, !drv_ready_n, !drv_ack_n};
        rd_v   = 8'h00;
        if (rd_ctrl)      rd_v = ctrl_q;
        else if (rd_stat) rd_v = stat_v;
    end

    assign drv_online_n = !ctrl_q[CB_ONLINE];
    assign drv_wr_en    = ctrl_q[CB_WREN];
    assign drv_rd_en    = ctrl_q[CB_RDEN];
    assign led_sel      = ctrl_q[CB_SEL];
    assign irq          = ctrl_q[CB_SEL] && (|flag_q);
endmodule

// File: rtl/tape_regfile_chk.sv
module tape_regfile_chk #(
    parameter int RST_HOLD = 5000
) (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_sel,
    input logic       bus_wr,
    input logic [7:0] bus_addr,
    input logic [7:0] bus_wdata,
    input logic       bus_ack,
    input logic       cmd_stb,
    input logic [7:0] cmd_data,
    input logic       drv_reset_n,
    input logic       tc_pulse,
    input logic       eoc_pulse,
    input logic [1:0] flag_q,
    input logic       led_sel,
    input logic       irq
);
    localparam int LW = $clog2(RST_HOLD + 2);
    logic [LW-1:0] low_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                             low_cnt <= '0;
        else if (drv_reset_n)                   low_cnt <= '0;
        else if (low_cnt != LW'(RST_HOLD + 1))  low_cnt <= low_cnt + 1'b1;
    end

    logic clr_w;
    assign clr_w = bus_sel && bus_wr && (bus_addr == 8'h88);

    AST_RST_MIN_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drv_reset_n) |-> (low_cnt >= LW'(RST_HOLD))); // R3
    AST_RST_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == 8'h82 && bus_wdata[1]) |=> !drv_reset_n); // R2
    AST_TC_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        tc_pulse |=> flag_q[0]); // R5
    AST_EOC_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        eoc_pulse |=> flag_q[1]); // R5
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q[0] && !clr_w) |=> flag_q[0]); // R5
    AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_w && !tc_pulse && !eoc_pulse) |=> (flag_q == 2'b00)); // R6
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !led_sel |-> !irq); // R7
    AST_ACK_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        bus_sel |=> bus_ack); // R10
    AST_NO_STRAY_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_sel |=> !bus_ack); // R10
    AST_CMD_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == 8'h80) |=> (cmd_stb && cmd_data == $past(bus_wdata))); // R8
    AST_CMD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_stb && !$past(bus_sel && bus_wr && bus_addr == 8'h80, 2)) |=> !cmd_stb); // R8
endmodule

bind tape_regfile tape_regfile_chk #(.RST_HOLD(RST_HOLD)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_ack    (bus_ack),
    .cmd_stb    (cmd_stb),
    .cmd_data   (cmd_data),
    .drv_reset_n(drv_reset_n),
    .tc_pulse   (tc_pulse),
    .eoc_pulse  (eoc_pulse),
    .flag_q     (flag_q),
    .led_sel    (led_sel),
    .irq        (irq)
);

// File: tb/test_tape_regfile.sv
module test_tape_regfile;
    localparam int HOLD = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_sel = 1'b0, bus_wr = 1'b0;
    logic [7:0] bus_addr = '0, bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic bus_ack;
    logic drv_reset_n, drv_online_n, drv_wr_en, drv_rd_en, led_sel;
    logic drv_ack_n = 1'b1, drv_ready_n = 1'b1, drv_exc_n = 1'b1, drv_dir = 1'b0;
    logic [7:0] cmd_data;
    logic cmd_stb;
    logic [23:0] dma_addr;
    logic tc_pulse = 1'b0, eoc_pulse = 1'b0;
    logic irq;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    tape_regfile #(.RST_HOLD(HOLD)) i_tape_regfile (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_ack(bus_ack),
        .drv_reset_n(drv_reset_n), .drv_online_n(drv_online_n),
        .drv_wr_en(drv_wr_en), .drv_rd_en(drv_rd_en), .led_sel(led_sel),
        .drv_ack_n(drv_ack_n), .drv_ready_n(drv_ready_n), .drv_exc_n(drv_exc_n), .drv_dir(drv_dir),
        .cmd_data(cmd_data), .cmd_stb(cmd_stb), .dma_addr(dma_addr),
        .tc_pulse(tc_pulse), .eoc_pulse(eoc_pulse), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        chk("R10 ack", 32'(bus_ack), 32'd1);
        d = bus_rdata;
    endtask

    task automatic pulse(input bit is_eoc);
        if (is_eoc) eoc_pulse = 1'b1; else tc_pulse = 1'b1;
        @(negedge clk);
        eoc_pulse = 1'b0; tc_pulse = 1'b0;
    endtask

    task automatic t_reset_state();
        logic [7:0] v;
        chk("R2 reset_n idle", 32'(drv_reset_n), 32'd1);
        chk("R2 online_n idle", 32'(drv_online_n), 32'd1);
        chk("R7 irq idle", 32'(irq), 32'd0);
        chk("R9 dma idle", 32'(dma_addr), 32'd0);
        chk("R10 ack idle", 32'(bus_ack), 32'd0);
        rd(8'h84, v);
        chk("R4 status idle", 32'(v), 32'h00);
    endtask

    task automatic t_ctrl();
        logic [7:0] v;
        wr(8'h82, 8'hE4);
        rd(8'h82, v);
        chk("R1 ctrl E4", 32'(v), 32'hE4);
        chk("R2 online_n", 32'(drv_online_n), 32'd0);
        chk("R2 wr_en", 32'(drv_wr_en), 32'd1);
        chk("R2 rd_en", 32'(drv_rd_en), 32'd1);
        chk("R2 led", 32'(led_sel), 32'd1);
        wr(8'h82, 8'h5D);
        rd(8'h82, v);
        chk("R1 ctrl reserved zero", 32'(v), 32'h44);
        chk("R2 wr_en off", 32'(drv_wr_en), 32'd0);
        chk("R2 led off", 32'(led_sel), 32'd0);
        wr(8'h82, 8'h00);
    endtask

    task automatic t_status_lines();
        logic [7:0] v;
        drv_ack_n = 1'b0; drv_dir = 1'b1;
        rd(8'h84, v);
        chk("R4 ack+dir", 32'(v), 32'h09);
        drv_ack_n = 1'b1; drv_dir = 1'b0; drv_ready_n = 1'b0; drv_exc_n = 1'b0;
        rd(8'h84, v);
        chk("R4 ready+exc", 32'(v), 32'h06);
        drv_ready_n = 1'b1; drv_exc_n = 1'b1;
    endtask

    task automatic t_cmd();
        wr(8'h80, 8'h40);
        chk("R8 stb high", 32'(cmd_stb), 32'd1);
        chk("R8 data 40", 32'(cmd_data), 32'h40);
        @(negedge clk);
        chk("R8 stb one cycle", 32'(cmd_stb), 32'd0);
        wr(8'h80, 8'h80);
        chk("R8 data 80", 32'(cmd_data), 32'h80);
    endtask

    task automatic t_dma();
        logic [7:0] v;
        wr(8'h8A, 8'h11);
        wr(8'h8C, 8'h22);
        wr(8'h8E, 8'h33);
        chk("R9 dma addr", 32'(dma_addr), 32'h332211);
        rd(8'h8C, v);
        chk("R9 dma write-only", 32'(v), 32'h00);
    endtask

    task automatic t_unmapped();
        logic [7:0] v;
        wr(8'h86, 8'hAA);
        wr(8'h02, 8'hFF);
        rd(8'h82, v);
        chk("R10 unmapped write ctrl", 32'(v), 32'h00);
        chk("R10 unmapped write dma", 32'(dma_addr), 32'h332211);
        rd(8'h86, v);
        chk("R10 unmapped read", 32'(v), 32'h00);
        rd(8'h80, v);
        chk("R10 cmd port read", 32'(v), 32'h00);
    endtask

    task automatic t_flags();
        logic [7:0] v;
        pulse(1'b0);
        repeat (3) @(negedge clk);
        rd(8'h84, v);
        chk("R5 tc sticky", 32'(v), 32'h10);
        pulse(1'b1);
        rd(8'h84, v);
        chk("R5 both flags", 32'(v), 32'h30);
        wr(8'h88, 8'h5A);
        rd(8'h84, v);
        chk("R6 clear", 32'(v), 32'h00);
    endtask

    task automatic t_clear_priority();
        logic [7:0] v;
        pulse(1'b1);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'h88; bus_wdata = 8'h00;
        tc_pulse = 1'b1;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; tc_pulse = 1'b0;
        rd(8'h84, v);
        chk("R6 set beats clear", 32'(v), 32'h10);
        wr(8'h88, 8'h00);
    endtask

    task automatic t_irq();
        logic [7:0] v;
        pulse(1'b0);
        chk("R7 irq gated off", 32'(irq), 32'd0);
        wr(8'h82, 8'h80);
        chk("R7 irq on", 32'(irq), 32'd1);
        wr(8'h88, 8'h00);
        chk("R7 irq after clear", 32'(irq), 32'd0);
        pulse(1'b1);
        chk("R7 irq eoc", 32'(irq), 32'd1);
        wr(8'h82, 8'h00);
        chk("R7 irq deselect", 32'(irq), 32'd0);
        rd(8'h84, v);
        chk("R7 flag kept", 32'(v), 32'h20);
        wr(8'h88, 8'h00);
    endtask

    task automatic t_rst_short();
        wr(8'h82, 8'h02);
        chk("R2 reset asserted", 32'(drv_reset_n), 32'd0);
        wr(8'h82, 8'h00);
        for (int i = 0; i < HOLD - 2; i++) begin
            @(negedge clk);
            if (drv_reset_n !== 1'b0) begin
                chk("R3 reset held", 32'(drv_reset_n), 32'd0);
                break;
            end
        end
        chk("R3 still low late", 32'(drv_reset_n), 32'd0);
        repeat (3) @(negedge clk);
        chk("R3 released", 32'(drv_reset_n), 32'd1);
    endtask

    task automatic t_rst_long();
        wr(8'h82, 8'h02);
        repeat (HOLD + 20) @(negedge clk);
        chk("R2 reset held by bit", 32'(drv_reset_n), 32'd0);
        wr(8'h82, 8'h00);
        repeat (2) @(negedge clk);
        chk("R3 release after bit", 32'(drv_reset_n), 32'd1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_ctrl();
        t_status_lines();
        t_cmd();
        t_dma();
        t_unmapped();
        t_flags();
        t_clear_priority();
        t_irq();
        t_rst_short();
        t_rst_long();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule